// File: doc/BRIEF.md
# Overwriting Result Spool with Byte-Serial Readout

This block holds finished conversion results from a converter core and returns them to a host one byte at a time over a chip-select / serial-clock / data-out link. The converter side presents a 10-bit result with a one-cycle valid strobe. The write side never stalls. When every slot is taken, a new result replaces the oldest stored one.

Each stored result leaves the block as a 16-bit word: four zero bits, then the 10-bit result with its most significant bit first, then two zero bits. The host opens one frame per byte by pulling chip select low. The upper byte of a word goes out in the first frame and the lower byte in the next one. An entry is released only when both of its bytes have been fully clocked out.

Both the chip select and the serial clock are oversampled by the system clock. The block reports empty, full and the number of stored entries.

Top module: `result_spool`

## Requirements
- R1: A synchronous active-high reset leaves empty=1, full=0, count=0 and dout=0, and it discards the byte phase.
- R2: Results come out in arrival order, with the oldest stored result first.
- R3: A result d[9:0] is sent as an upper byte {0000, d[9:6]} followed by a lower byte {d[5:0], 00}, with bit 7 of each byte first.
- R4: Up to DEPTH (16) results are held. count gives the number held, and full is 1 exactly when count equals DEPTH.
- R5: A write while full discards the oldest entry and stores the new one. count stays at DEPTH.
- R6: A frame opened while the store is empty shifts out eight zero bits and changes no state.
- R7: A frame closed after fewer than 8 rising serial-clock edges does not advance the readout. The next frame repeats the same byte.
- R8: count falls by one only when a lower byte completes. Completing an upper byte leaves count unchanged.
- R9: An overwrite that drops the oldest entry while it is partly read restarts the readout. The next frame starts with the upper byte of the new oldest entry, and a frame in progress during the overwrite does not advance the readout.
- R10: Bit 7 is on dout before the first serial-clock edge of a frame. dout changes only at a chip-select falling edge or a serial-clock falling edge.
- R11: A reset applied in the middle of operation empties the store. A following frame returns zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; it also oversamples cs_n and sclk |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Result strobe from the converter core |
| wr_data | input | 10 | Conversion result |
| cs_n | input | 1 | Active-low frame select; a falling edge opens a byte frame |
| sclk | input | 1 | Serial clock; idles low, and the host samples on its rising edge |
| dout | output | 1 | Serial data, with bit 7 of the byte first |
| empty | output | 1 | No result is stored |
| full | output | 1 | DEPTH results are stored |
| count | output | 5 | Number of stored results |

## Verification
The assertions take for granted that cs_n and sclk are slow against clk. Each level must be held for several system clocks so that the edge detectors see clean edges. A chip-select edge and a serial-clock edge must never fall in the same sampled cycle.

The bench holds every serial-clock half period for four system clocks. It keeps the serial clock low whenever chip select moves, and it changes cs_n only between bit slots. Writes are issued only between frames, except in the directed case that overwrites in the middle of a frame.

// File: rtl/spool_pkg.sv
package spool_pkg;
  localparam int RES_W      = 10;
  localparam int BYTE_W     = 8;
  localparam int LEAD_ZEROS = 4;
  localparam int WORD_W     = 2 * BYTE_W;
  localparam int TAIL_ZEROS = WORD_W - LEAD_ZEROS - RES_W;

  typedef enum logic {
    PH_UPPER = 1'b0,
    PH_LOWER = 1'b1
  } byte_half_e;

  // Build the padded word and return the requested byte of it.
  function automatic logic [BYTE_W-1:0] take_byte(input logic [RES_W-1:0] res,
                                                  input byte_half_e half);
    logic [WORD_W-1:0] word;
    word = {{LEAD_ZEROS{1'b0}}, res, {TAIL_ZEROS{1'b0}}};
    return (half == PH_UPPER) ? word[WORD_W-1:BYTE_W] : word[BYTE_W-1:0];
  endfunction
endpackage

// File: rtl/spool_edge.sv
module spool_edge #(
  parameter logic IDLE = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic rise,
  output logic fall
);
  logic now_q;
  logic old_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      now_q <= IDLE;
      old_q <= IDLE;
    end else begin
      now_q <= pin;
      old_q <= now_q;
    end
  end

  assign rise = now_q & ~old_q;
  assign fall = ~now_q & old_q;
endmodule

// File: rtl/spool_ring.sv
module spool_ring #(
  parameter int DEPTH = 16,
  parameter int W     = 10,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop_req,
  output logic [W-1:0]  head_data,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          full,
  output logic          drop
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] rd_ptr;
  logic          do_pop;
  logic          grow;
  logic [CW-1:0] cnt_nxt;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // Plain write port, no reset: maps onto distributed RAM.
  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  assign head_data = mem[rd_ptr];
  assign do_pop    = pop_req & ~empty;
  assign drop      = push & full & ~do_pop;
  assign grow      = push & (~full | do_pop);
  assign cnt_nxt   = count + CW'(grow) - CW'(do_pop);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      empty  <= 1'b1;
      full   <= 1'b0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (do_pop || drop) rd_ptr <= bump(rd_ptr);
      count <= cnt_nxt;
      empty <= (cnt_nxt == '0);
      full  <= (cnt_nxt == CW'(DEPTH));
    end
  end
endmodule

// File: rtl/spool_serializer.sv
module spool_serializer
  import spool_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_fall,
  input  logic             cs_rise,
  input  logic             sclk_rise,
  input  logic             sclk_fall,
  input  logic             store_empty,
  input  logic [RES_W-1:0] head_data,
  input  logic             drop,
  output logic             pop_req,
  output logic             dout
);
  localparam int BCW = $clog2(BYTE_W + 1);

  logic [BYTE_W-1:0] shreg;
  logic [BYTE_W-1:0] fresh;
  logic [BCW-1:0]    edges;
  byte_half_e        half;
  logic              live;
  logic              in_frame;
  logic              dout_q;
  logic              frame_done;

  assign fresh      = store_empty ? '0 : take_byte(head_data, half);
  assign frame_done = cs_rise & in_frame & live & (edges == BCW'(BYTE_W));
  assign pop_req    = frame_done & (half == PH_LOWER);
  assign dout       = dout_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg    <= '0;
      edges    <= '0;
      half     <= PH_UPPER;
      live     <= 1'b0;
      in_frame <= 1'b0;
      dout_q   <= 1'b0;
    end else begin
      if (cs_fall) begin
        dout_q   <= fresh[BYTE_W-1];
        shreg    <= {fresh[BYTE_W-2:0], 1'b0};
        edges    <= '0;
        live     <= ~store_empty;
        in_frame <= 1'b1;
      end else if (in_frame) begin
        if (sclk_rise && edges != BCW'(BYTE_W)) edges <= edges + 1'b1;
        if (sclk_fall) begin
          dout_q <= shreg[BYTE_W-1];
          shreg  <= {shreg[BYTE_W-2:0], 1'b0};
        end
        if (cs_rise) in_frame <= 1'b0;
      end
      if (frame_done) half <= (half == PH_UPPER) ? PH_LOWER : PH_UPPER;
      // Losing the head entry restarts the word and voids the open frame.
      if (drop) begin
        half <= PH_UPPER;
        live <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/result_spool.sv
module result_spool
  import spool_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_valid,
  input  logic [RES_W-1:0] wr_data,
  input  logic             cs_n,
  input  logic             sclk,
  output logic             dout,
  output logic             empty,
  output logic             full,
  output logic [CW-1:0]    count
);
  localparam int NPINS = 2;
  localparam logic [NPINS-1:0] PIN_IDLE = 2'b01; // [0] cs_n idles high, [1] sclk idles low

  logic [NPINS-1:0] pins;
  logic [NPINS-1:0] rises;
  logic [NPINS-1:0] falls;
  logic             cs_fall, cs_rise, sclk_rise, sclk_fall;
  logic [RES_W-1:0] head_data;
  logic             pop_req;
  logic             drop;

  assign pins = {sclk, cs_n};

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    spool_edge #(.IDLE(PIN_IDLE[g])) u_edge (
      .clk (clk),
      .rst (rst),
      .pin (pins[g]),
      .rise(rises[g]),
      .fall(falls[g])
    );
  end

  assign cs_fall   = falls[0];
  assign cs_rise   = rises[0];
  assign sclk_fall = falls[1];
  assign sclk_rise = rises[1];

  spool_ring #(.DEPTH(DEPTH), .W(RES_W)) u_ring (
    .clk      (clk),
    .rst      (rst),
    .push     (wr_valid),
    .push_data(wr_data),
    .pop_req  (pop_req),
    .head_data(head_data),
    .count    (count),
    .empty    (empty),
    .full     (full),
    .drop     (drop)
  );

  spool_serializer u_ser (
    .clk        (clk),
    .rst        (rst),
    .cs_fall    (cs_fall),
    .cs_rise    (cs_rise),
    .sclk_rise  (sclk_rise),
    .sclk_fall  (sclk_fall),
    .store_empty(empty),
    .head_data  (head_data),
    .drop       (drop),
    .pop_req    (pop_req),
    .dout       (dout)
  );
endmodule

// File: rtl/spool_checks.sv
module spool_checks #(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_valid,
  input logic          dout,
  input logic          empty,
  input logic          full,
  input logic [CW-1:0] count,
  input logic          cs_fall,
  input logic          sclk_fall
);
  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= 1'b1;

  // R1
  a_r1_reset_state: assert property (@(posedge clk)
    armed && $past(rst) |-> empty && !full && count == '0 && dout == 1'b0);

  // R4
  a_r4_count_bound: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));

  // R4
  a_r4_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(empty && full));

  // R5
  a_r5_full_write_stays_full: assert property (@(posedge clk) disable iff (rst)
    full && wr_valid |=> full);

  // R6
  a_r6_empty_frame_low: assert property (@(posedge clk) disable iff (rst)
    empty && cs_fall |=> dout == 1'b0);

  // R8
  a_r8_count_single_step: assert property (@(posedge clk) disable iff (rst)
    armed && !$past(rst) |-> (count == $past(count)) ||
                             (count == $past(count) + 1'b1) ||
                             (count + 1'b1 == $past(count)));

  // R10
  a_r10_dout_moves_on_edges: assert property (@(posedge clk) disable iff (rst)
    !cs_fall && !sclk_fall |=> $stable(dout));
endmodule

bind result_spool spool_checks #(.DEPTH(DEPTH)) u_checks (
  .clk      (clk),
  .rst      (rst),
  .wr_valid (wr_valid),
  .dout     (dout),
  .empty    (empty),
  .full     (full),
  .count    (count),
  .cs_fall  (cs_fall),
  .sclk_fall(sclk_fall)
);

// File: tb/result_spool_test.sv
module result_spool_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 16;
  localparam int HALF       = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_valid = 1'b0;
  logic [9:0] wr_data = '0;
  logic       cs_n = 1'b1;
  logic       sclk = 1'b0;
  logic       dout;
  logic       empty, full;
  logic [4:0] count;

  int  total = 0;
  int  bad   = 0;
  bit  finished = 1'b0;
  int  q[$];
  bit  ph = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  result_spool #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_data(wr_data),
    .cs_n(cs_n), .sclk(sclk), .dout(dout), .empty(empty), .full(full), .count(count)
  );

  function automatic logic [7:0] hi_b(input logic [9:0] d);
    return {4'b0000, d[9:6]};
  endfunction

  function automatic logic [7:0] lo_b(input logic [9:0] d);
    return {d[5:0], 2'b00};
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [9:0] d);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_data  = d;
    @(negedge clk);
    wr_valid = 1'b0;
    if (q.size() == DEPTH) begin
      void'(q.pop_front());
      ph = 1'b0;
    end
    q.push_back(int'(d));
  endtask

  task automatic read_byte(input int nbits, input bit mid_wr, input logic [9:0] mid_d,
                           output logic [7:0] got, output logic [7:0] expv);
    bit live, killed;
    got    = '0;
    live   = (q.size() != 0);
    killed = 1'b0;
    expv   = !live ? 8'h00 : (ph ? lo_b(10'(q[0])) : hi_b(10'(q[0])));
    @(negedge clk);
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      got[7-i] = dout;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      check(dout == got[7-i], "R10 dout held across rising sclk", dout, got[7-i]);
      sclk = 1'b0;
      repeat (HALF) @(negedge clk);
      if (mid_wr && i == 3) begin
        if (q.size() == DEPTH) killed = 1'b1;
        do_write(mid_d);
      end
    end
    cs_n = 1'b1;
    repeat (HALF) @(negedge clk);
    if (nbits == 8 && live && !killed) begin
      if (ph) begin
        void'(q.pop_front());
        ph = 1'b0;
      end else begin
        ph = 1'b1;
      end
    end
  endtask

  task automatic read_check(input string tag);
    logic [7:0] got, expv;
    read_byte(8, 1'b0, 10'd0, got, expv);
    check(got == expv, tag, got, expv);
  endtask

  task automatic check_flags(input string tag);
    check(count == 5'(q.size()), tag, count, q.size());
    check(empty == (q.size() == 0) && full == (q.size() == DEPTH), tag,
          {empty, full}, {q.size() == 0, q.size() == DEPTH});
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    q.delete();
    ph = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] got, expv;
    void'($urandom(32'h5eed_1234));
    do_reset();
    // R1 reset state
    check(empty == 1'b1 && full == 1'b0 && count == 0 && dout == 1'b0, "R1 reset state",
          {empty, full, count, dout}, 8'b1000_0000);

    // R6 empty frame gives zeros, no state change
    read_check("R6 empty byte");
    check_flags("R6 empty unchanged");

    // R2 R3 R8 ordered readout with padding
    do_write(10'h3FF);
    do_write(10'h155);
    do_write(10'h2A3);
    check_flags("R4 count after three writes");
    read_check("R3 upper byte of first");
    check_flags("R8 count kept after upper byte");
    read_check("R3 lower byte of first");
    check_flags("R8 count drops after lower byte");
    for (int i = 0; i < 4; i++) read_check("R2 arrival order");
    check_flags("R2 drained");

    // R7 early frame repeats the byte
    do_write(10'h2C1);
    read_byte(3, 1'b0, 10'd0, got, expv);
    read_check("R7 upper byte repeated after short frame");
    read_byte(7, 1'b0, 10'd0, got, expv);
    read_check("R7 lower byte repeated after short frame");
    check_flags("R7 state after recovery");

    // R4 R5 overflow keeps newest DEPTH entries
    for (int i = 0; i < DEPTH + 4; i++) do_write(10'(i * 37 + 5));
    check_flags("R5 full after overflow");
    check(q[0] == 4 * 37 + 5, "R5 model oldest survivor", q[0], 4 * 37 + 5);
    for (int i = 0; i < 2 * DEPTH; i++) read_check("R5 survivors in order");
    check_flags("R5 drained");

    // R9 overwrite between the two bytes of the oldest entry
    for (int i = 0; i < DEPTH; i++) do_write(10'(i + 100));
    read_check("R9 upper byte before overwrite");
    do_write(10'h3A5);
    read_check("R9 restart with upper byte of new oldest");
    check_flags("R9 count after overwrite");

    // R9 overwrite in the middle of a frame
    read_byte(8, 1'b1, 10'h1C7, got, expv);
    check(got == expv, "R9 byte in flight during overwrite", got, expv);
    read_check("R9 upper byte after mid-frame overwrite");
    read_check("R9 lower byte after mid-frame overwrite");
    while (q.size() != 0) read_check("R2 drain after overwrite");
    check_flags("R9 drained");

    // Random mix
    for (int n = 0; n < 300; n++) begin
      int r;
      r = $urandom_range(0, 9);
      if (r < 4) do_write(10'($urandom_range(0, 1023)));
      else if (r < 8) read_check("R2 R3 random readout");
      else read_byte($urandom_range(0, 7), 1'b0, 10'd0, got, expv);
      check_flags("R4 R8 random flags");
    end

    // R11 reset mid-operation
    do_write(10'h0F0);
    do_write(10'h00F);
    read_byte(4, 1'b0, 10'd0, got, expv);
    do_reset();
    check(empty == 1'b1 && count == 0 && full == 1'b0, "R11 cleared by reset",
          {empty, full, count}, 7'b1000000);
    read_check("R11 zeros after reset");

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule